// File: doc/BRIEF.md
# Text-Mode Character Display Generator

This block turns a grid of character codes into a one-bit pixel stream for a 480x272 panel using 8x8 glyphs, giving 60 text columns and 34 text rows. No pixel image is stored. Each pixel is found as it is needed: the raster position selects a cell in the code buffer, and the code read from that cell selects a glyph in a computed font ROM.

Two free-running counters produce the raster position. Both counters are zero at the first visible pixel. This lets both memory addresses be built by slicing the counter bits, with no adder. The code buffer is 64x64 cells of eight bits. It has an independent host write port, addressed by text row and column, and a display read port. The buffer comes out of configuration holding a preset pattern, so the panel shows text before any host write.

Each of the two memories adds one clock of latency. For that reason the low raster bits, display-enable and both syncs go through matching delay stages. The pixel, display-enable and syncs therefore all leave the block in the same cycle for the same screen position.

Top module: `txt_disp_gen`

## Requirements
- R1: While rst_n is low, the outputs are held at pix_bit=0, disp_en=0, hsync_n=1 and vsync_n=1. After reset is released, the raster starts at column 0 of line 0, and the outputs for that position appear two clocks later.
- R2: A line lasts 523 clocks and a frame lasts 284 lines. disp_en is high exactly for horizontal positions 0..479 on lines 0..271, and it is delayed by two clocks from the raster position.
- R3: hsync_n is low for horizontal positions 484..503 and vsync_n is low for lines 274..277. Both are active low and have the same two-clock delay as disp_en.
- R4: For a visible position (h,v), pix_bit is bit (h mod 8) of the glyph row G = code XOR ((v mod 8) * 37 mod 256). Here code is the character code of the cell that covers the position.
- R5: The cell covering position (h,v) is text column h/8 and text row v/8, which is buffer address {row[5:0], col[5:0]}.
- R6: pix_bit is 0 whenever disp_en is 0, whatever the buffer and font produce.
- R7: Before any host write, cell (row r, column c) holds (c + 5*r) mod 256.
- R8: A clock edge with wr_en high stores wr_code into the cell at (wr_row, wr_col). Every later display read of that cell returns the new code.
- R9: Cells with column 60..63 or row 34..63 are never shown, so writes to them have no effect on the pixel stream.
- R10: The horizontal counter steps by one every clock and wraps from 522 to 0. The vertical counter changes only at that wrap, and it wraps from 283 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; also clocks the host write port |
| rst_n | input | 1 | Asynchronous active-low reset of counters and pipeline |
| wr_en | input | 1 | Host write strobe |
| wr_row | input | 6 | Text row of the cell to write |
| wr_col | input | 6 | Text column of the cell to write |
| wr_code | input | 8 | Character code to store |
| pix_bit | output | 1 | Monochrome pixel value |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| disp_en | output | 1 | High during the visible area |

## Verification
The hardest situation to reach from the ports is proving that every glyph bit sits at its exact screen position. An error of one cycle in any delay stage shifts the whole image by one pixel, yet the sync and enable timing can still look correct on their own. The stimulus therefore runs through one complete frame and predicts each output from the raster position alone. This covers all 60x34 visible cells and all eight glyph rows and columns in each cell. Before the frame starts, the bench writes into visible and hidden cells while reset is held. That places known codes at the corner cells, and it also leaves codes in the hidden cells that would appear on screen if the address slicing were wrong.

// File: rtl/txt_disp_pkg.sv
package txt_disp_pkg;

  localparam int unsigned CODE_W = 8;

  // One row of a glyph: eight pixel bits, LSB is leftmost column.
  function automatic logic [CODE_W-1:0] glyph_row(input logic [CODE_W-1:0] code,
                                                  input logic [2:0]        row);
    logic [CODE_W-1:0] mix;
    mix = CODE_W'(row) * CODE_W'(37);
    return code ^ mix;
  endfunction

  // Preset contents of the code buffer.
  function automatic logic [CODE_W-1:0] preset_code(input int unsigned r,
                                                    input int unsigned c);
    int unsigned s;
    s = (c + 5 * r) % 256;
    return CODE_W'(s);
  endfunction

  // Sync window test: true when pos lies in [start, start+width).
  function automatic logic in_window(input int unsigned pos,
                                     input int unsigned start,
                                     input int unsigned width);
    return (pos >= start) && (pos < start + width);
  endfunction

endpackage

// File: rtl/txt_raster_timer.sv
module txt_raster_timer
  import txt_disp_pkg::*;
#(
  parameter int unsigned H_ACT = 480,
  parameter int unsigned H_FP  = 4,
  parameter int unsigned H_SW  = 20,
  parameter int unsigned H_BP  = 19,
  parameter int unsigned V_ACT = 272,
  parameter int unsigned V_FP  = 2,
  parameter int unsigned V_SW  = 4,
  parameter int unsigned V_BP  = 6,
  localparam int unsigned H_TOT = H_ACT + H_FP + H_SW + H_BP,
  localparam int unsigned V_TOT = V_ACT + V_FP + V_SW + V_BP,
  localparam int unsigned HW    = $clog2(H_TOT),
  localparam int unsigned VW    = $clog2(V_TOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          line_end,
  output logic          frame_end,
  output logic          active,
  output logic          hsync_n,
  output logic          vsync_n
);

  assign line_end  = (hcnt == HW'(H_TOT - 1));
  assign frame_end = line_end && (vcnt == VW'(V_TOT - 1));
  assign active    = (hcnt < HW'(H_ACT)) && (vcnt < VW'(V_ACT));
  assign hsync_n   = !in_window(int'(hcnt), H_ACT + H_FP, H_SW);
  assign vsync_n   = !in_window(int'(vcnt), V_ACT + V_FP, V_SW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= frame_end ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

endmodule

// File: rtl/txt_code_ram.sv
module txt_code_ram
  import txt_disp_pkg::*;
#(
  parameter int unsigned COL_BITS = 6,
  parameter int unsigned ROW_BITS = 6,
  localparam int unsigned AW    = COL_BITS + ROW_BITS,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [CODE_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [CODE_W-1:0] rdata
);

  logic [CODE_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      mem[i] = preset_code(i >> COL_BITS, i & ((1 << COL_BITS) - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/txt_glyph_rom.sv
module txt_glyph_rom
  import txt_disp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic [2:0]        row,
  input  logic [2:0]        col,
  output logic              bit_q
);

  logic [CODE_W-1:0] row_bits;

  always_comb row_bits = glyph_row(code, row);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= row_bits[col];
  end

endmodule

// File: rtl/txt_disp_gen.sv
module txt_disp_gen
  import txt_disp_pkg::*;
#(
  parameter int unsigned H_ACT    = 480,
  parameter int unsigned H_FP     = 4,
  parameter int unsigned H_SW     = 20,
  parameter int unsigned H_BP     = 19,
  parameter int unsigned V_ACT    = 272,
  parameter int unsigned V_FP     = 2,
  parameter int unsigned V_SW     = 4,
  parameter int unsigned V_BP     = 6,
  parameter int unsigned COL_BITS = 6,
  parameter int unsigned ROW_BITS = 6,
  localparam int unsigned GLY     = 3,
  localparam int unsigned H_TOT   = H_ACT + H_FP + H_SW + H_BP,
  localparam int unsigned V_TOT   = V_ACT + V_FP + V_SW + V_BP,
  localparam int unsigned HW      = $clog2(H_TOT),
  localparam int unsigned VW      = $clog2(V_TOT),
  localparam int unsigned AW      = COL_BITS + ROW_BITS,
  localparam int unsigned DLY     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ROW_BITS-1:0] wr_row,
  input  logic [COL_BITS-1:0] wr_col,
  input  logic [CODE_W-1:0]   wr_code,
  output logic                pix_bit,
  output logic                hsync_n,
  output logic                vsync_n,
  output logic                disp_en
);

  // Raster stage 0
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          line_end, frame_end, active0, hs0_n, vs0_n;

  txt_raster_timer #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP)
  ) u_timer (
    .clk(clk), .rst_n(rst_n),
    .hcnt(hcnt), .vcnt(vcnt),
    .line_end(line_end), .frame_end(frame_end),
    .active(active0), .hsync_n(hs0_n), .vsync_n(vs0_n)
  );

  // Address formation by bit slicing
  logic [AW-1:0] rd_addr, wr_addr;
  assign rd_addr = {vcnt[GLY +: ROW_BITS], hcnt[GLY +: COL_BITS]};
  assign wr_addr = {wr_row, wr_col};

  // Stage 1: code fetch
  logic [CODE_W-1:0] cell_code;

  txt_code_ram #(.COL_BITS(COL_BITS), .ROW_BITS(ROW_BITS)) u_buf (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_code),
    .raddr(rd_addr), .rdata(cell_code)
  );

  logic [GLY-1:0] sub_col1, sub_row1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_col1 <= '0;
      sub_row1 <= '0;
    end else begin
      sub_col1 <= hcnt[GLY-1:0];
      sub_row1 <= vcnt[GLY-1:0];
    end
  end

  // Stage 2: glyph bit lookup
  logic glyph_bit;

  txt_glyph_rom u_font (
    .clk(clk), .rst_n(rst_n),
    .code(cell_code), .row(sub_row1), .col(sub_col1),
    .bit_q(glyph_bit)
  );

  // Control delay line, one entry per memory stage
  logic [DLY:0] de_pipe, hs_pipe, vs_pipe;
  assign de_pipe[0] = active0;
  assign hs_pipe[0] = hs0_n;
  assign vs_pipe[0] = vs0_n;

  for (genvar k = 1; k <= DLY; k++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        de_pipe[k] <= 1'b0;
        hs_pipe[k] <= 1'b1;
        vs_pipe[k] <= 1'b1;
      end else begin
        de_pipe[k] <= de_pipe[k-1];
        hs_pipe[k] <= hs_pipe[k-1];
        vs_pipe[k] <= vs_pipe[k-1];
      end
    end
  end

  assign disp_en = de_pipe[DLY];
  assign hsync_n = hs_pipe[DLY];
  assign vsync_n = vs_pipe[DLY];
  assign pix_bit = glyph_bit & disp_en;

endmodule

// File: rtl/txt_disp_chk.sv
module txt_disp_chk #(
  parameter int unsigned H_TOT = 523,
  parameter int unsigned V_TOT = 284,
  parameter int unsigned HW    = 10,
  parameter int unsigned VW    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic [HW-1:0] hcnt,
  input logic [VW-1:0] vcnt,
  input logic          pix_bit,
  input logic          disp_en,
  input logic          hsync_n,
  input logic          vsync_n
);

  assert_hwrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt == HW'(H_TOT - 1) |=> hcnt == '0);

  assert_hstep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt != HW'(H_TOT - 1) |=> (hcnt == $past(hcnt) + 1'b1) && $stable(vcnt));

  assert_vwrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == HW'(H_TOT - 1)) && (vcnt == VW'(V_TOT - 1)) |=> vcnt == '0);

  assert_blank_pix_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_bit |-> disp_en);

  assert_hsync_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> !disp_en);

  assert_vsync_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> !disp_en);

endmodule

bind txt_disp_gen txt_disp_chk #(
  .H_TOT(H_TOT), .V_TOT(V_TOT), .HW(HW), .VW(VW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
  .pix_bit(pix_bit), .disp_en(disp_en), .hsync_n(hsync_n), .vsync_n(vsync_n)
);

// File: tb/sim_txt_disp_gen.sv
module sim_txt_disp_gen;

  localparam int CLK_NS  = 10;
  localparam int HT      = 523;
  localparam int VT      = 284;
  localparam int FRAME   = HT * VT;
  localparam int WDOG    = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [5:0] wr_row, wr_col;
  logic [7:0] wr_code;
  logic       pix_bit, hsync_n, vsync_n, disp_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int shadow [4096];

  always #(CLK_NS / 2) clk = ~clk;

  txt_disp_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
    .wr_col(wr_col), .wr_code(wr_code), .pix_bit(pix_bit),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .disp_en(disp_en)
  );

  task automatic check(input string req, input int act, input int exp, input int idx);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at index %0d: actual %0d expected %0d", req, idx, act, exp);
    end
  endtask

  task automatic host_put(input int r, input int c, input int code);
    wr_en   = 1'b1;
    wr_row  = 6'(r);
    wr_col  = 6'(c);
    wr_code = 8'(code);
    @(negedge clk);
    wr_en   = 1'b0;
    shadow[r * 64 + c] = code;
  endtask

  function automatic int exp_pixel(input int h, input int v);
    int code, g;
    code = shadow[(v / 8) * 64 + (h / 8)];
    g    = (code ^ (((v % 8) * 37) % 256)) & 255;
    return (g >> (h % 8)) & 1;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * WDOG);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_row = '0; wr_col = '0; wr_code = '0;
    // R7: preset model
    for (int r = 0; r < 64; r++)
      for (int c = 0; c < 64; c++)
        shadow[r * 64 + c] = (c + 5 * r) % 256;
    repeat (3) @(negedge clk);

    // R8: writes to visible cells, including corners
    host_put(0, 0, 8'hA5);
    host_put(33, 59, 8'h3C);
    host_put(10, 20, 8'hFF);
    host_put(5, 5, 8'h00);
    host_put(33, 0, 8'h81);
    // R9: writes to hidden cells
    host_put(0, 60, 8'hFF);
    host_put(0, 63, 8'h77);
    host_put(34, 0, 8'hFF);
    host_put(63, 63, 8'h55);
    host_put(1, 1, 8'h5A);
    host_put(1, 1, 8'h96);   // R8: second write wins

    // R1: outputs during reset
    check("R1 pix in reset", pix_bit, 0, -1);
    check("R1 de in reset", disp_en, 0, -1);
    check("R1 hsync in reset", hsync_n, 1, -1);
    check("R1 vsync in reset", vsync_n, 1, -1);

    rst_n = 1'b1;
    for (int m = 0; m < FRAME + 2; m++) begin
      if (m < 2) begin
        check("R1 pix after reset", pix_bit, 0, m);
        check("R1 de after reset", disp_en, 0, m);
        check("R1 hsync after reset", hsync_n, 1, m);
        check("R1 vsync after reset", vsync_n, 1, m);
      end else begin
        int i, h, v, de, hs, vs, px;
        i  = m - 2;
        h  = i % HT;
        v  = i / HT;
        de = (h < 480 && v < 272) ? 1 : 0;
        hs = (h >= 484 && h < 504) ? 0 : 1;
        vs = (v >= 274 && v < 278) ? 0 : 1;
        // R4 R5 R6 R8 R9: glyph bit from the cell under the position
        px = de ? exp_pixel(h, v) : 0;
        check("R2 disp_en", disp_en, de, i);
        check("R3 hsync_n", hsync_n, hs, i);
        check("R3 vsync_n", vsync_n, vs, i);
        check(de ? "R4 pixel" : "R6 blank pixel", pix_bit, px, i);
      end
      @(negedge clk);
    end
    // R10: raster wrapped back to the first visible pixel (2-cycle delay)
    @(negedge clk);
    check("R10 wrap de", disp_en, 1, FRAME);
    check("R10 wrap pixel", pix_bit, exp_pixel(1, 0), FRAME);
    finish_run();
  end

endmodule